// File: doc/BRIEF.md
# Paged Register Window Bridge

This block sits on the device side of a 16-bit management register port and serves a small window of registers at one management address. Through that window, software reaches a much larger internal register space: 8-bit pages, 8-bit offsets, and registers up to 64 bits wide. Software first selects a page. It then fills or reads four 16-bit data slots and issues read or write commands through a command register. The block turns those commands into single-cycle requests on a simple internal register bus.

A command does not finish when it is written. It marks the command register busy, and the internal access happens after a fixed number of cycles set by a parameter. Software detects completion by polling the command register until its request bits clear. If the page enable flag is clear when a command is accepted, the command still runs its full latency but sends no request to the internal bus.

Top module: `regwin_bridge`

## Requirements
- R1: After reset, the page, enable, offset, request bits and all four data slots read as zero, and `ib_req` is low.
- R2: The page register at address 0x10 holds the page in bits 15:8 and the enable flag in bit 0. Bits 7:1 read as zero whatever was written to them.
- R3: The data slots at 0x18, 0x19, 0x1A and 0x1B hold bits 15:0, 31:16, 47:32 and 63:48 of the 64-bit data word. Each reads back what was last written to it.
- R4: The command register at 0x11 holds the offset in bits 15:8, a write request in bit 0 and a read request in bit 1. Bits 7:2 read as zero.
- R5: A write request causes exactly one `ib_req` cycle with `ib_we` high, the page and offset captured when the command was accepted, and `ib_wdata` equal to the four data slots joined together (slot 0x18 least significant).
- R6: A read request causes exactly one `ib_req` cycle with `ib_we` low. In that same cycle, the four data slots are loaded from the matching 16-bit fields of `ib_rdata`.
- R7: If a command has both request bits set, it runs as a write, and only bit 0 reads back as set.
- R8: While a request is pending, writes to the command register are ignored. The offset and request bits do not change, and no extra internal request is made.
- R9: If the enable flag is clear when a request is accepted, the request completes after the same latency, with no `ib_req` and with the data slots unchanged.
- R10: After a request is accepted, its request bit reads as set for exactly `LAT` cycles and then clears by itself.
- R11: Any other address reads as zero, and writing to it changes no window register.
- R12: A command write with neither request bit set only stores the offset and starts no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mg_req | input | 1 | Management access strobe |
| mg_we | input | 1 | Management write when high |
| mg_addr | input | 5 | Management register address |
| mg_wdata | input | 16 | Management write data |
| mg_rdata | output | 16 | Management read data for `mg_addr`, combinational |
| ib_req | output | 1 | One-cycle internal access strobe |
| ib_we | output | 1 | Internal access is a write |
| ib_page | output | 8 | Internal page |
| ib_offs | output | 8 | Internal register offset |
| ib_wdata | output | 64 | Internal write data |
| ib_rdata | input | 64 | Internal read data, valid in the `ib_req` cycle |

## Verification
The assertions check on every cycle that:
- at most one request bit is set;
- internal strobes occur only while a request is pending, with `ib_we` matching its kind;
- every strobe clears the busy bits;
- a read strobe loads the data slots;
- a command written while busy leaves the offset unchanged;
- busy spans exactly `LAT` cycles.

Only the bench scenarios can show the following, because each needs a model of what software wrote:
- the field layout of each window register;
- the ordering of the data slots within the 64-bit word;
- the write-over-read priority;
- the silent completion when the page is disabled.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    parameter int WIN_ADDR_W = 5;

    localparam logic [WIN_ADDR_W-1:0] A_PAGE  = 5'h10;
    localparam logic [WIN_ADDR_W-1:0] A_CMD   = 5'h11;
    localparam logic [WIN_ADDR_W-1:0] A_DATA0 = 5'h18;

    localparam int CMD_WR_BIT = 0;
    localparam int CMD_RD_BIT = 1;
    localparam int PAGE_EN_BIT = 0;
endpackage

// File: rtl/regwin_timer.sv
module regwin_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic expire
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LAT - 1);
        end else if (active && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = active && (cnt_q == '0);
endmodule

// File: rtl/regwin_lanes.sv
module regwin_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_we,
    input  logic [DATA_W-1:0]        lane_wdata,
    input  logic                     load,
    input  logic [DATA_W*LANES-1:0]  load_data,
    output logic [DATA_W*LANES-1:0]  word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DATA_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (load)            slot_d = load_data[i*DATA_W +: DATA_W];
            else if (lane_we[i]) slot_d = lane_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign word[i*DATA_W +: DATA_W] = slot_q;
    end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int LAT    = 3,
    parameter int DATA_W = 16,
    parameter int LANES  = 4,
    parameter int PAGE_W = 8,
    parameter int OFFS_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mg_req,
    input  logic                      mg_we,
    input  logic [WIN_ADDR_W-1:0]     mg_addr,
    input  logic [DATA_W-1:0]         mg_wdata,
    output logic [DATA_W-1:0]         mg_rdata,
    output logic                      ib_req,
    output logic                      ib_we,
    output logic [PAGE_W-1:0]         ib_page,
    output logic [OFFS_W-1:0]         ib_offs,
    output logic [DATA_W*LANES-1:0]   ib_wdata,
    input  logic [DATA_W*LANES-1:0]   ib_rdata
);
    localparam int WORD_W = DATA_W * LANES;
    localparam int MID_P  = DATA_W - PAGE_W - 1;
    localparam int MID_C  = DATA_W - OFFS_W - 2;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              pen;
        logic [OFFS_W-1:0] offs;
        logic              wr_busy;
        logic              rd_busy;
        logic [PAGE_W-1:0] acc_page;
        logic              acc_en;
    } state_t;

    state_t st_d, st_q;

    logic              busy;
    logic              expire;
    logic              start;
    logic              wr_page, wr_cmd;
    logic [LANES-1:0]  lane_we;
    logic              load_rd;
    logic [WORD_W-1:0] word;

    // names visible to the bound checker
    logic              wr_busy_w, rd_busy_w;
    logic [OFFS_W-1:0] offs_w;
    logic [WORD_W-1:0] word_w;

    assign busy    = st_q.wr_busy | st_q.rd_busy;
    assign wr_page = mg_req && mg_we && (mg_addr == A_PAGE);
    assign wr_cmd  = mg_req && mg_we && (mg_addr == A_CMD);

    for (genvar i = 0; i < LANES; i++) begin : g_dec
        assign lane_we[i] = mg_req && mg_we &&
                            (mg_addr == WIN_ADDR_W'(int'(A_DATA0) + i));
    end

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (wr_page) begin
            st_d.page = mg_wdata[DATA_W-1 -: PAGE_W];
            st_d.pen  = mg_wdata[PAGE_EN_BIT];
        end
        if (busy && expire) begin
            st_d.wr_busy = 1'b0;
            st_d.rd_busy = 1'b0;
        end
        if (wr_cmd && !busy) begin
            st_d.offs     = mg_wdata[DATA_W-1 -: OFFS_W];
            st_d.acc_page = st_q.page;
            st_d.acc_en   = st_q.pen;
            if (mg_wdata[CMD_WR_BIT]) begin
                st_d.wr_busy = 1'b1;
                start        = 1'b1;
            end else if (mg_wdata[CMD_RD_BIT]) begin
                st_d.rd_busy = 1'b1;
                start        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    regwin_timer #(.LAT(LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (busy),
        .expire (expire)
    );

    assign ib_req   = busy && expire && st_q.acc_en;
    assign ib_we    = st_q.wr_busy;
    assign ib_page  = st_q.acc_page;
    assign ib_offs  = st_q.offs;
    assign ib_wdata = word;
    assign load_rd  = ib_req && !st_q.wr_busy;

    regwin_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_we    (lane_we),
        .lane_wdata (mg_wdata),
        .load       (load_rd),
        .load_data  (ib_rdata),
        .word       (word)
    );

    always_comb begin
        mg_rdata = '0;
        if (mg_addr == A_PAGE) begin
            mg_rdata = {st_q.page, {MID_P{1'b0}}, st_q.pen};
        end else if (mg_addr == A_CMD) begin
            mg_rdata = {st_q.offs, {MID_C{1'b0}}, st_q.rd_busy, st_q.wr_busy};
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (mg_addr == WIN_ADDR_W'(int'(A_DATA0) + i))
                    mg_rdata = word[i*DATA_W +: DATA_W];
            end
        end
    end

    assign wr_busy_w = st_q.wr_busy;
    assign rd_busy_w = st_q.rd_busy;
    assign offs_w    = st_q.offs;
    assign word_w    = word;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
    import regwin_pkg::*;
#(
    parameter int LAT    = 3,
    parameter int WORD_W = 64,
    parameter int OFFS_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mg_req,
    input logic                  mg_we,
    input logic [WIN_ADDR_W-1:0] mg_addr,
    input logic                  ib_req,
    input logic                  ib_we,
    input logic [WORD_W-1:0]     ib_rdata,
    input logic                  wr_busy,
    input logic                  rd_busy,
    input logic [OFFS_W-1:0]     offs,
    input logic [WORD_W-1:0]     word
);
    logic        busy;
    logic [15:0] span_q;

    assign busy = wr_busy | rd_busy;

    always_ff @(posedge clk) begin
        if (!rst_n)     span_q <= '0;
        else if (!busy) span_q <= '0;
        else            span_q <= span_q + 16'd1;
    end

    // R7
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_busy, rd_busy}));

    // R5
    req_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> (busy && ib_we == wr_busy));

    // R10
    req_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |=> !busy);

    // R6
    read_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_we) |=> (word == $past(ib_rdata)));

    // R8
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mg_req && mg_we && mg_addr == A_CMD) |=> $stable(offs));

    // R10
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (span_q == 16'(LAT)));
endmodule

bind regwin_bridge regwin_chk #(
    .LAT    (LAT),
    .WORD_W (DATA_W*LANES),
    .OFFS_W (OFFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mg_req   (mg_req),
    .mg_we    (mg_we),
    .mg_addr  (mg_addr),
    .ib_req   (ib_req),
    .ib_we    (ib_we),
    .ib_rdata (ib_rdata),
    .wr_busy  (wr_busy_w),
    .rd_busy  (rd_busy_w),
    .offs     (offs_w),
    .word     (word_w)
);

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mg_req = 1'b0, mg_we = 1'b0;
    logic [4:0]  mg_addr = '0;
    logic [15:0] mg_wdata = '0;
    logic [15:0] mg_rdata;
    logic        ib_req, ib_we;
    logic [7:0]  ib_page, ib_offs;
    logic [63:0] ib_wdata, ib_rdata;

    always #2 clk = ~clk;

    function automatic logic [63:0] fake_rd(input logic [7:0] p, input logic [7:0] o);
        return {p, o, 8'hA5, ~p, o ^ p, 8'h3C, p + o, ~o};
    endfunction

    assign ib_rdata = fake_rd(ib_page, ib_offs);

    regwin_bridge #(.LAT(LAT)) u_regwin_bridge (
        .clk(clk), .rst_n(rst_n), .mg_req(mg_req), .mg_we(mg_we),
        .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_page(ib_page), .ib_offs(ib_offs),
        .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
    );

    int vectors = 0, fails = 0;
    int req_cnt = 0;
    logic        cap_we;
    logic [7:0]  cap_page, cap_offs;
    logic [63:0] cap_wdata;

    always @(negedge clk) begin
        if (rst_n && ib_req) begin
            req_cnt++;
            cap_we = ib_we; cap_page = ib_page; cap_offs = ib_offs; cap_wdata = ib_wdata;
        end
    end

    // bench model
    logic [7:0]  m_page = '0;
    logic        m_en = 1'b0;
    logic [7:0]  m_offs = '0;
    logic [15:0] m_data [4];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
        mg_req = 1'b1; mg_we = 1'b1; mg_addr = a; mg_wdata = d;
        @(negedge clk);
        mg_req = 1'b0; mg_we = 1'b0;
    endtask

    task automatic mread(input logic [4:0] a, output logic [15:0] d);
        mg_addr = a;
        #1 d = mg_rdata;
        @(negedge clk);
    endtask

    function automatic logic [63:0] m_word();
        return {m_data[3], m_data[2], m_data[1], m_data[0]};
    endfunction

    task automatic check_slots(input string req);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            mread(5'(5'h18 + i), v);
            check(req, v, m_data[i]);
        end
    endtask

    task automatic set_page(input logic [7:0] p, input logic en, input logic [6:0] junk);
        logic [15:0] v;
        mwrite(5'h10, {p, junk, en});
        m_page = p; m_en = en;
        mread(5'h10, v);
        check("R2 page readback", v, {p, 7'b0, en});
    endtask

    task automatic set_slot(input int i, input logic [15:0] d);
        mwrite(5'(5'h18 + i), d);
        m_data[i] = d;
    endtask

    task automatic run_cmd(input logic [7:0] o, input logic [1:0] bits);
        int prev, polls;
        logic [15:0] v;
        logic is_wr, is_rd;
        logic [63:0] rd;
        prev = req_cnt;
        is_wr = bits[0];
        is_rd = !bits[0] && bits[1];
        mwrite(5'h11, {o, 6'b0, bits});
        m_offs = o;
        if (!is_wr && !is_rd) begin
            mread(5'h11, v);
            check("R12 offset only", v, {o, 8'h00});
            check("R12 no access", 64'(req_cnt), 64'(prev));
            return;
        end
        polls = 0;
        mread(5'h11, v);
        check(is_wr ? "R7/R4 write bit set" : "R4 read bit set", v,
              {o, 6'b0, is_rd, is_wr});
        while (v[1:0] != 2'b00 && polls < 50) begin
            polls++;
            mread(5'h11, v);
        end
        check("R10 busy span", 64'(polls), 64'(LAT));
        check("R4 bits self-clear", v, {o, 8'h00});
        if (!m_en) begin
            check("R9 no request when disabled", 64'(req_cnt), 64'(prev));
            check_slots("R9 slots unchanged");
        end else begin
            check(is_wr ? "R5 one request" : "R6 one request", 64'(req_cnt), 64'(prev + 1));
            check(is_wr ? "R5 kind" : "R6 kind", 64'(cap_we), 64'(is_wr));
            check("R5 page/offset", {48'b0, cap_page, cap_offs}, {48'b0, m_page, o});
            if (is_wr) begin
                check("R5 write data", cap_wdata, m_word());
            end else begin
                rd = fake_rd(m_page, o);
                for (int i = 0; i < 4; i++) m_data[i] = rd[i*16 +: 16];
                check_slots("R6 slots loaded");
                check("R3 slot order on bus", ib_wdata, rd);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int prev;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        mread(5'h10, v); check("R1 page reset", v, 16'h0);
        mread(5'h11, v); check("R1 cmd reset", v, 16'h0);
        check_slots("R1 slots reset");
        check("R1 ib_req low", 64'(ib_req), 64'd0);

        // R3 slot order
        set_slot(0, 16'h1111); set_slot(1, 16'h2222);
        set_slot(2, 16'h3333); set_slot(3, 16'h4444);
        check_slots("R3 slot readback");
        check("R3 word order", ib_wdata, 64'h4444_3333_2222_1111);

        // R9 disabled page
        set_page(8'h12, 1'b0, 7'h55);
        run_cmd(8'h20, 2'b01);
        run_cmd(8'h21, 2'b10);

        // R5, R6, R7
        set_page(8'hA7, 1'b1, 7'h7F);
        run_cmd(8'h30, 2'b01);
        run_cmd(8'h31, 2'b10);
        run_cmd(8'h32, 2'b11);
        run_cmd(8'h33, 2'b00);

        // R8 command while pending
        prev = req_cnt;
        mwrite(5'h11, {8'h40, 8'h02});
        mwrite(5'h11, {8'h41, 8'h01});
        mread(5'h11, v);
        check("R8 busy cmd ignored", v, {8'h40, 8'h02});
        repeat (LAT + 2) @(negedge clk);
        check("R8 single request", 64'(req_cnt), 64'(prev + 1));
        check("R8 kind kept", 64'(cap_we), 64'd0);
        begin
            logic [63:0] rd;
            rd = fake_rd(8'hA7, 8'h40);
            for (int i = 0; i < 4; i++) m_data[i] = rd[i*16 +: 16];
        end
        check_slots("R8 read completed once");
        m_offs = 8'h40;

        // R11 unmapped
        mwrite(5'h12, 16'hFFFF);
        mwrite(5'h00, 16'hFFFF);
        mread(5'h12, v); check("R11 unmapped reads zero", v, 16'h0);
        mread(5'h1F, v); check("R11 unmapped reads zero", v, 16'h0);
        mread(5'h10, v); check("R11 page untouched", v, {m_page, 7'b0, m_en});
        mread(5'h11, v); check("R11 cmd untouched", v, {m_offs, 8'h00});
        check_slots("R11 slots untouched");

        // constrained random
        for (int n = 0; n < 60; n++) begin
            int pick;
            pick = int'($urandom_range(0, 3));
            if (pick == 0) begin
                set_page(8'($urandom), ($urandom_range(0, 3) != 0), 7'($urandom));
            end else if (pick == 1) begin
                set_slot(int'($urandom_range(0, 3)), 16'($urandom));
            end else begin
                run_cmd(8'($urandom), 2'($urandom));
            end
        end
        check_slots("R3 final slots");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule